// File: doc/BRIEF.md
# Test Access Port Command Sequencer

This block drives the pins of an IEEE 1149.1 test access port on behalf of a host. The host writes one command word: an operation, a stable end state, a 32-bit cycle count, a scan data mode and a capture source. The block then generates TCK, TMS and serial output data until the target sits in the requested end state. A one-clock `done` pulse marks the end of the command. The block keeps its own copy of the target's TAP controller state. Every TMS decision is derived from that copy and the commanded destination, so any stable state can be reached from any other without stored TMS strings.

The operations are a plain state move, a run-test that holds the target in Run-Test/Idle for a counted number of TCK cycles, and instruction or data scans of a counted number of bits. A scan either exchanges data in both directions, only captures, only drives, or recirculates the returned stream back onto its output. The bits it captures can come from the target or, for self-test, from the block's own TDO or TMS stream. Serial data is exchanged with the host one bit at a time through `tx_bit`/`tx_take` and `rx_valid`/`rx_bit`.

Top module: `tapm_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `tap_tck` are 0, and `tap_state` is 0 (Test-Logic-Reset).
- R2: `tap_state` tracks the target controller with encoding 0 TLR, 1 RTI, 2 SelDR, 3 CapDR, 4 ShiftDR, 5 Exit1DR, 6 PauseDR, 7 Exit2DR, 8 UpdDR, 9 SelIR, 10 CapIR, 11 ShiftIR, 12 Exit1IR, 13 PauseIR, 14 Exit2IR, 15 UpdIR. It changes only on a TCK rising edge. A move (`cmd_op`=0) reaches any end state, coded in `cmd_end` as 0 TLR, 1 RTI, 2 ShiftDR, 3 PauseDR, 4 ShiftIR, 5 PauseIR, from any stable state. The command then ends with a `done` pulse and `busy` low.
- R3: TCK is held low while idle. While busy it toggles once per clock, so one TCK period takes two clocks.
- R4: TMS and TDO change only while TCK falls or stays low. They never change at a TCK rising edge, which is the edge where returned data is sampled.
- R5: A move to Test-Logic-Reset from any other state uses exactly five TCK cycles with TMS=1. From Test-Logic-Reset it uses none.
- R6: A scan (`cmd_op` 2 = instruction, 3 = data) shifts exactly `cmd_count` bits in the matching shift state. TMS is 1 only on the last bit, and the scan then ends in the end state. In mode 0 each bit is taken from `tx_bit`, with one `tx_take` pulse per bit, and each captured bit appears as one `rx_valid` pulse.
- R7: In mode 1 (input-only), TDO is held at 1, there is no `tx_take`, and every bit is captured. In mode 2 (output-only), bits are taken from `tx_bit` and `rx_valid` never rises.
- R8: In mode 3 (recirculate), the first bit drives 0 and bit k drives the TDI value sampled on bit k-1. No `tx_take` occurs and every bit is captured.
- R9: `cmd_lsel` selects the captured bit: 1 gives the block's own TDO bit, 2 gives its own TMS bit, and 0 or 3 gives the target's `tap_di`.
- R10: A run-test (`cmd_op`=1) gives exactly `cmd_count` TCK cycles in Run-Test/Idle with TMS=0, then moves to the end state.
- R11: A scan or run-test with `cmd_count`=0 acts as a move. It shifts no bits, gives no run-test cycles, and produces no `tx_take` or `rx_valid`.
- R12: A command written while busy is ignored and sets `err`. A command whose end code is 6 or 7 is rejected and sets `err`. The next accepted command clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_op | input | 2 | 0 move, 1 run-test, 2 instruction scan, 3 data scan |
| cmd_end | input | 3 | Stable end state code |
| cmd_mode | input | 2 | Scan data mode |
| cmd_lsel | input | 2 | Capture source select |
| cmd_count | input | 32 | Bits to scan or run-test cycles |
| tx_bit | input | 1 | Next serial bit to drive |
| tx_take | output | 1 | Pulse: `tx_bit` consumed |
| rx_valid | output | 1 | Pulse: `rx_bit` holds a captured bit |
| rx_bit | output | 1 | Captured serial bit |
| busy | output | 1 | Command in progress |
| done | output | 1 | Pulse at command completion |
| err | output | 1 | Rejected command flag |
| tap_state | output | 4 | Tracked target state |
| tap_tck | output | 1 | Test clock |
| tap_tms | output | 1 | Test mode select |
| tap_do | output | 1 | Serial data to target |
| tap_di | input | 1 | Serial data from target |

## Verification
Moves are tried between every ordered pair of stable states. This exposes any wrong step in the per-state TMS rules, because a single bad rule leaves the target model and `tap_state` apart. Scans run in each of the four data modes and with each capture source. Checking TDO and `rx_bit` at every TCK rising edge tells the modes apart by which bit is driven and which bit comes back. Run-test and scan counts of zero, a move into Test-Logic-Reset from itself and from a deep state, a write during a busy command and an illegal end code each isolate one of the counting or rejection rules.

// File: rtl/tapm_pkg.sv
package tapm_pkg;

    typedef enum logic [3:0] {
        TS_TLR    = 4'd0,  TS_RTI    = 4'd1,  TS_SELDR = 4'd2,  TS_CAPDR = 4'd3,
        TS_SHDR   = 4'd4,  TS_EX1DR  = 4'd5,  TS_PSDR  = 4'd6,  TS_EX2DR = 4'd7,
        TS_UPDDR  = 4'd8,  TS_SELIR  = 4'd9,  TS_CAPIR = 4'd10, TS_SHIR  = 4'd11,
        TS_EX1IR  = 4'd12, TS_PSIR   = 4'd13, TS_EX2IR = 4'd14, TS_UPDIR = 4'd15
    } tap_st_e;

    typedef enum logic [1:0] {OP_MOVE = 2'd0, OP_IDLE = 2'd1, OP_SIR = 2'd2, OP_SDR = 2'd3} op_e;
    typedef enum logic [1:0] {MD_BOTH = 2'd0, MD_IN = 2'd1, MD_OUT = 2'd2, MD_RECIRC = 2'd3} mode_e;
    typedef enum logic [1:0] {SG_PRE = 2'd0, SG_WORK = 2'd1, SG_POST = 2'd2} stage_e;

    // Stable end-state code to controller state.
    function automatic tap_st_e end_code_to_st(input logic [2:0] code);
        case (code)
            3'd1:    return TS_RTI;
            3'd2:    return TS_SHDR;
            3'd3:    return TS_PSDR;
            3'd4:    return TS_SHIR;
            3'd5:    return TS_PSIR;
            default: return TS_TLR;
        endcase
    endfunction

endpackage

// File: rtl/tapm_walk.sv
// Next controller state for one TCK rising edge.
module tapm_walk
    import tapm_pkg::*;
(
    input  tap_st_e cur,
    input  logic    tms,
    output tap_st_e nxt
);
    always_comb begin
        case (cur)
            TS_TLR:   nxt = tms ? TS_TLR   : TS_RTI;
            TS_RTI:   nxt = tms ? TS_SELDR : TS_RTI;
            TS_SELDR: nxt = tms ? TS_SELIR : TS_CAPDR;
            TS_CAPDR: nxt = tms ? TS_EX1DR : TS_SHDR;
            TS_SHDR:  nxt = tms ? TS_EX1DR : TS_SHDR;
            TS_EX1DR: nxt = tms ? TS_UPDDR : TS_PSDR;
            TS_PSDR:  nxt = tms ? TS_EX2DR : TS_PSDR;
            TS_EX2DR: nxt = tms ? TS_UPDDR : TS_SHDR;
            TS_UPDDR: nxt = tms ? TS_SELDR : TS_RTI;
            TS_SELIR: nxt = tms ? TS_TLR   : TS_CAPIR;
            TS_CAPIR: nxt = tms ? TS_EX1IR : TS_SHIR;
            TS_SHIR:  nxt = tms ? TS_EX1IR : TS_SHIR;
            TS_EX1IR: nxt = tms ? TS_UPDIR : TS_PSIR;
            TS_PSIR:  nxt = tms ? TS_EX2IR : TS_PSIR;
            TS_EX2IR: nxt = tms ? TS_UPDIR : TS_SHIR;
            default:  nxt = tms ? TS_SELDR : TS_RTI;
        endcase
    end
endmodule

// File: rtl/tapm_route.sv
// One TMS step toward a stable, non-reset destination; never passes through reset.
module tapm_route
    import tapm_pkg::*;
(
    input  tap_st_e cur,
    input  tap_st_e dst,
    output logic    tms
);
    logic dst_dr, dst_ir;

    always_comb begin
        dst_dr = (dst == TS_SHDR) || (dst == TS_PSDR);
        dst_ir = (dst == TS_SHIR) || (dst == TS_PSIR);
        case (cur)
            TS_TLR:   tms = 1'b0;
            TS_SELDR: tms = dst_ir;
            TS_CAPDR: tms = (dst != TS_SHDR);
            TS_EX1DR: tms = !dst_dr;
            TS_EX2DR: tms = (dst != TS_SHDR);
            TS_UPDDR: tms = (dst != TS_RTI);
            TS_SELIR: tms = 1'b0;
            TS_CAPIR: tms = (dst != TS_SHIR);
            TS_EX1IR: tms = !dst_ir;
            TS_EX2IR: tms = (dst != TS_SHIR);
            TS_UPDIR: tms = (dst != TS_RTI);
            default:  tms = 1'b1;   // RTI and the shift/pause states leave via TMS=1
        endcase
    end
endmodule

// File: rtl/tapm_seq.sv
module tapm_seq
    import tapm_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int TLR_ONES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [1:0]       cmd_op,
    input  logic [2:0]       cmd_end,
    input  logic [1:0]       cmd_mode,
    input  logic [1:0]       cmd_lsel,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             tx_bit,
    output logic             tx_take,
    output logic             rx_valid,
    output logic             rx_bit,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [3:0]       tap_state,
    output logic             tap_tck,
    output logic             tap_tms,
    output logic             tap_do,
    input  logic             tap_di
);
    localparam int RW = $clog2(TLR_ONES + 1);
    localparam logic [RW-1:0] RST_LAST = RW'(TLR_ONES);

    typedef struct packed {
        logic             busy;
        logic             tck;
        logic             armed;   // TMS/TDO set up, rising edge pending
        logic             tms;
        logic             tdo;
        logic             shift;   // pending rising edge shifts a bit
        stage_e           stage;
        op_e              op;
        mode_e            mode;
        logic [1:0]       lsel;
        tap_st_e          st;
        tap_st_e          dst;
        logic [CNT_W-1:0] cnt;
        logic [RW-1:0]    rcnt;
        logic             lastdi;
        logic             done;
        logic             err;
        logic             take;
        logic             rxv;
        logic             rxb;
    } regs_t;

    regs_t   q, d;
    tap_st_e nxt_st, work_st;
    logic    tms_work, tms_end, in_work, is_scan;

    tapm_walk  u_walk (.cur(q.st), .tms(q.tms), .nxt(nxt_st));
    tapm_route u_rwork(.cur(q.st), .dst(work_st), .tms(tms_work));
    tapm_route u_rend (.cur(q.st), .dst(q.dst),   .tms(tms_end));

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.take  = 1'b0;
        d.rxv   = 1'b0;
        is_scan = (q.op == OP_SIR) || (q.op == OP_SDR);
        work_st = (q.op == OP_SIR) ? TS_SHIR : ((q.op == OP_SDR) ? TS_SHDR : TS_RTI);
        in_work = (q.stage == SG_WORK) || (q.stage == SG_PRE && q.st == work_st);

        if (q.busy) begin
            if (!q.tck && q.armed) begin
                // TCK rising: target advances, returned bit sampled
                d.tck   = 1'b1;
                d.armed = 1'b0;
                d.st    = nxt_st;
                if (q.shift) begin
                    d.lastdi = tap_di;
                    if (q.mode != MD_OUT) begin
                        d.rxv = 1'b1;
                        case (q.lsel)
                            2'd1:    d.rxb = q.tdo;
                            2'd2:    d.rxb = q.tms;
                            default: d.rxb = tap_di;
                        endcase
                    end
                end
            end else begin
                // TCK falling (or first set-up): choose the next TMS/TDO
                d.tck   = 1'b0;
                d.shift = 1'b0;
                if (q.stage == SG_PRE && !in_work) begin
                    d.tms   = tms_work;
                    d.armed = 1'b1;
                end else if (in_work && q.cnt != '0) begin
                    d.stage = SG_WORK;
                    d.cnt   = q.cnt - 1'b1;
                    d.armed = 1'b1;
                    if (is_scan) begin
                        d.tms   = (q.cnt == CNT_W'(1));
                        d.shift = 1'b1;
                        case (q.mode)
                            MD_IN:     d.tdo = 1'b1;
                            MD_RECIRC: d.tdo = q.lastdi;
                            default: begin
                                d.tdo  = tx_bit;
                                d.take = 1'b1;
                            end
                        endcase
                    end else begin
                        d.tms = 1'b0;
                    end
                end else begin
                    d.stage = SG_POST;
                    if (q.dst == TS_TLR) begin
                        if (q.rcnt == RST_LAST || (q.rcnt == '0 && q.st == TS_TLR)) begin
                            d.busy = 1'b0;
                            d.done = 1'b1;
                        end else begin
                            d.tms   = 1'b1;
                            d.rcnt  = q.rcnt + 1'b1;
                            d.armed = 1'b1;
                        end
                    end else if (q.st == q.dst) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.tms   = tms_end;
                        d.armed = 1'b1;
                    end
                end
            end
        end

        if (cmd_we) begin
            if (q.busy || cmd_end > 3'd5) begin
                d.err = 1'b1;
            end else begin
                d.busy   = 1'b1;
                d.tck    = 1'b0;
                d.armed  = 1'b0;
                d.shift  = 1'b0;
                d.op     = op_e'(cmd_op);
                d.mode   = mode_e'(cmd_mode);
                d.lsel   = cmd_lsel;
                d.dst    = end_code_to_st(cmd_end);
                d.cnt    = cmd_count;
                d.rcnt   = '0;
                d.lastdi = 1'b0;
                d.err    = 1'b0;
                d.stage  = (op_e'(cmd_op) == OP_MOVE || cmd_count == '0) ? SG_POST : SG_PRE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= TS_TLR;
            q.dst   <= TS_TLR;
            q.stage <= SG_POST;
            q.op    <= OP_MOVE;
            q.mode  <= MD_BOTH;
            q.tms   <= 1'b1;
            q.tdo   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_take   = q.take;
    assign rx_valid  = q.rxv;
    assign rx_bit    = q.rxb;
    assign busy      = q.busy;
    assign done      = q.done;
    assign err       = q.err;
    assign tap_state = q.st;
    assign tap_tck   = q.tck;
    assign tap_tms   = q.tms;
    assign tap_do    = q.tdo;

endmodule

// File: rtl/tapm_chk.sv
module tapm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       tck,
    input logic       tms,
    input logic       tdo,
    input logic [3:0] st,
    input logic       rxv,
    input logic       take
);
    a_r3_tck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    a_r4_pins_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> ($stable(tms) && $stable(tdo)));

    a_r2_state_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st) |-> $rose(tck));

    a_r2_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !tck));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy) |=> err);

    a_r6_rx_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rxv |-> $rose(tck));

    a_r6_take_on_low_tck: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (busy && !tck));
endmodule

bind tapm_seq tapm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .busy(busy), .done(done), .err(err),
    .tck(tap_tck), .tms(tap_tms), .tdo(tap_do), .st(tap_state), .rxv(rx_valid), .take(tx_take)
);

// File: tb/sim_tapm_seq.sv
`timescale 1ns/1ps
module sim_tapm_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_end = '0;
    logic [1:0]  cmd_mode = '0;
    logic [1:0]  cmd_lsel = '0;
    logic [31:0] cmd_count = '0;
    logic        tx_bit, tx_take, rx_valid, rx_bit, busy, done, err;
    logic [3:0]  tap_state;
    logic        tap_tck, tap_tms, tap_do, tap_di;

    int checks = 0;
    int fails = 0;

    // target model and per-command bookkeeping
    int          mst = 0;
    logic [31:0] dr_ch = '0;
    logic [31:0] ir_ch = '0;
    logic        prev_tck = 1'b0;
    logic        rc_prev = 1'b0;
    logic [63:0] txv = '0;
    int tx_idx = 0;
    int c_op = 0, c_md = 0, c_ls = 0;
    int nshift = 0, nones = 0, nrti = 0, ntake = 0, nrxv = 0;

    always #10 clk = ~clk;

    assign tx_bit = txv[tx_idx[5:0]];
    assign tap_di = (mst == 11) ? ir_ch[0] : dr_ch[0];

    tapm_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_end(cmd_end),
        .cmd_mode(cmd_mode), .cmd_lsel(cmd_lsel), .cmd_count(cmd_count),
        .tx_bit(tx_bit), .tx_take(tx_take), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .busy(busy), .done(done), .err(err), .tap_state(tap_state),
        .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_do(tap_do), .tap_di(tap_di)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tgt_next(input int s, input logic t);
        case (s)
            0:  return t ? 0  : 1;
            1:  return t ? 2  : 1;
            2:  return t ? 9  : 3;
            3:  return t ? 5  : 4;
            4:  return t ? 5  : 4;
            5:  return t ? 8  : 6;
            6:  return t ? 7  : 6;
            7:  return t ? 8  : 4;
            8:  return t ? 2  : 1;
            9:  return t ? 0  : 10;
            10: return t ? 12 : 11;
            11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return t ? 2 : 1;
        endcase
    endfunction

    function automatic int code_st(input int c);
        case (c)
            1: return 1;
            2: return 4;
            3: return 6;
            4: return 11;
            5: return 13;
            default: return 0;
        endcase
    endfunction

    // Reference target model, compared every clock away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit   rise, in_sh, exp_rxv;
            logic exp_bit, exp_do;
            rise  = tap_tck && !prev_tck;
            in_sh = (c_op == 3 && mst == 4) || (c_op == 2 && mst == 11);
            if (!busy) begin
                if (tap_tck !== 1'b0) chk(0, "R3 tck idle", tap_tck, 0);
                if (tap_state !== 4'(mst)) chk(0, "R2 state track", tap_state, mst);
            end
            exp_rxv = rise && in_sh && (c_md != 2);
            if (rx_valid !== exp_rxv) chk(0, "R6 rx_valid", rx_valid, exp_rxv);
            if (exp_rxv) begin
                exp_bit = (c_ls == 1) ? tap_do : ((c_ls == 2) ? tap_tms : tap_di);
                chk(rx_bit === exp_bit, "R9 rx_bit", rx_bit, exp_bit);
                nrxv++;
            end
            if (rise) begin
                if (in_sh) begin
                    case (c_md)
                        1:       exp_do = 1'b1;
                        3:       exp_do = rc_prev;
                        default: exp_do = txv[nshift];
                    endcase
                    chk(tap_do === exp_do, (c_md == 3) ? "R8 recirc tdo" : "R7 scan tdo", tap_do, exp_do);
                    rc_prev = tap_di;
                    nshift++;
                end
                if (tap_tms) nones++;
                if (c_op == 1 && mst == 1 && !tap_tms) nrti++;
                if (mst == 4)  dr_ch = {tap_do, dr_ch[31:1]};
                if (mst == 11) ir_ch = {tap_do, ir_ch[31:1]};
                mst = tgt_next(mst, tap_tms);
            end
            if (tx_take) begin
                tx_idx++;
                ntake++;
            end
            prev_tck = tap_tck;
        end
    end

    task automatic start(input int op, input int en, input int cnt, input int md, input int ls);
        c_op = op; c_md = md; c_ls = ls;
        nshift = 0; nones = 0; nrti = 0; ntake = 0; nrxv = 0;
        rc_prev = 1'b0; tx_idx = 0;
        @(negedge clk);
        cmd_op = op[1:0]; cmd_end = en[2:0]; cmd_count = cnt[31:0];
        cmd_mode = md[1:0]; cmd_lsel = ls[1:0]; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!done && w < 4000);
        if (w >= 4000) chk(0, "R2 command never completed", w, 0);
    endtask

    task automatic issue(input int op, input int en, input int cnt, input int md, input int ls);
        start(op, en, cnt, md, ls);
        wait_done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && err == 0, "R1 status after reset", {busy, done, err}, 0);
        chk(tap_tck == 0, "R1 tck after reset", tap_tck, 0);
        chk(tap_state == 0, "R1 state after reset", tap_state, 0);

        // R5: reset move from reset costs no cycles
        issue(0, 0, 0, 0, 0);
        chk(nones == 0, "R5 reset from reset", nones, 0);

        // R2: every ordered pair of stable end states
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                issue(0, a, 0, 0, 0);
                issue(0, b, 0, 0, 0);
                chk(tap_state == 4'(code_st(b)) && mst == code_st(b), "R2 pair move", tap_state, code_st(b));
            end
        end

        // R5: five ones from a deep state
        issue(0, 5, 0, 0, 0);
        issue(0, 0, 0, 0, 0);
        chk(nones == 5, "R5 five TMS ones", nones, 5);
        chk(tap_state == 0, "R5 ends in reset", tap_state, 0);

        // R6: data scan, both directions, 8 bits
        dr_ch = 32'h0000_00A5;
        txv = 64'h0000_0000_0000_0036;
        issue(3, 1, 8, 0, 0);
        chk(nshift == 8 && ntake == 8 && nrxv == 8, "R6 scan bit counts", nshift, 8);
        chk(dr_ch[31:24] == 8'h36, "R6 data reached target", dr_ch[31:24], 8'h36);
        chk(tap_state == 1, "R6 scan end state", tap_state, 1);

        // R7: input-only instruction scan
        ir_ch = 32'h0000_002D;
        issue(2, 5, 6, 1, 0);
        chk(nshift == 6 && ntake == 0 && nrxv == 6, "R7 input-only counts", ntake, 0);
        chk(ir_ch[31:26] == 6'h3F, "R7 input-only drives ones", ir_ch[31:26], 6'h3F);
        chk(tap_state == 13, "R7 input-only end", tap_state, 13);

        // R7: output-only data scan
        txv = 64'h0000_0000_0000_0013;
        issue(3, 3, 5, 2, 0);
        chk(nrxv == 0 && ntake == 5, "R7 output-only counts", nrxv, 0);
        chk(dr_ch[31:27] == 5'h13, "R7 output-only data", dr_ch[31:27], 5'h13);

        // R8: recirculate ending in ShiftDR
        dr_ch = 32'h0000_0059;
        issue(3, 2, 7, 3, 0);
        chk(nshift == 7 && ntake == 0 && nrxv == 7, "R8 recirc counts", ntake, 0);
        chk(dr_ch[31:25] == 7'h32, "R8 recirc stream", dr_ch[31:25], 7'h32);
        chk(tap_state == 4, "R8 recirc end state", tap_state, 4);

        // R9: loopback of own TDO, then own TMS
        txv = 64'h0000_0000_0000_002B;
        issue(3, 1, 6, 0, 1);
        chk(nrxv == 6, "R9 tdo loopback count", nrxv, 6);
        issue(2, 1, 4, 0, 2);
        chk(nrxv == 4, "R9 tms loopback count", nrxv, 4);

        // R10: run-test
        issue(1, 1, 10, 0, 0);
        chk(nrti == 10, "R10 idle cycles from RTI", nrti, 10);
        issue(0, 0, 0, 0, 0);
        issue(1, 3, 3, 0, 0);
        chk(nrti == 3, "R10 idle cycles from reset", nrti, 3);
        chk(tap_state == 6, "R10 end state", tap_state, 6);

        // R11: zero-count scan and run-test
        issue(0, 1, 0, 0, 0);
        issue(3, 4, 0, 0, 0);
        chk(nshift == 0 && nrxv == 0 && ntake == 0, "R11 zero scan", nshift, 0);
        chk(tap_state == 11, "R11 zero scan end", tap_state, 11);
        issue(1, 3, 0, 0, 0);
        chk(nrti == 0 && tap_state == 6, "R11 zero run-test", nrti, 0);

        // R12: write while busy is ignored
        issue(0, 1, 0, 0, 0);
        start(1, 1, 20, 0, 0);
        repeat (3) @(negedge clk);
        cmd_op = 2'd0; cmd_end = 3'd2; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(err == 1, "R12 err on busy write", err, 1);
        wait_done();
        chk(tap_state == 1 && nrti == 20, "R12 busy write ignored", tap_state, 1);
        issue(0, 3, 0, 0, 0);
        chk(err == 0, "R12 err cleared by accept", err, 0);

        // R12: illegal end code
        @(negedge clk);
        cmd_op = 2'd0; cmd_end = 3'd6; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(err == 1 && busy == 0, "R12 illegal end rejected", {err, busy}, 2);
        repeat (4) @(negedge clk);
        chk(tap_state == 6 && tap_tck == 0, "R12 illegal end no effect", tap_state, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule